// File: doc/BRIEF.md
# Snooping MESI Line Controller

This block is the coherence engine of one small private cache. The cache is direct-mapped and write-back. Each line holds a tag, a single data word and a two-bit coherence state. The core side takes read and write requests and answers every one with a response that says whether it hit. It drives `core_req_ready` low while the cache owns an outstanding bus transaction. When a request needs the shared bus, the controller raises a bus request with an opcode and holds it until `bus_gnt`. It then waits for `bus_done`, which carries fill data and a shared indication gathered from the other caches.

At the same time the controller watches every transaction that another cache broadcasts. It reports whether it holds the addressed line. It supplies data cache-to-cache when it is the owner of a clean-exclusive or dirty copy. It downgrades or invalidates its copy as the snooped opcode demands. A dirty line that must give way to a conflicting fill is first written back with its own bus transaction.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid (encoding I=2'b00, S=2'b01, E=2'b10, M=2'b11). `core_req_ready` is high, `bus_req_valid` is low, and a snoop to any address reports `snp_hold` low.
- R2: A read miss raises a bus request with opcode 1 (read). The line is filled with `bus_fill_data` as Exclusive when `bus_shared` is low at completion, and as Shared when it is high. The response has hit=0 and returns the fill data.
- R3: A read hit answers with hit=1 and the stored word one cycle after acceptance, with no bus request.
- R4: A write hit on an Exclusive or Modified line stores the word and leaves the line Modified with no bus request. The response has hit=1.
- R5: A write hit on a Shared line requests opcode 3 (upgrade), and the line becomes Modified with the written word only at completion. If a snoop invalidates the line before the grant, the request turns into opcode 2 (read-for-ownership).
- R6: A write miss requests opcode 2 (read-for-ownership). The line ends Modified holding the written word, and the response has hit=0.
- R7: A snooped read (opcode 1) that hits an Exclusive or Modified line asserts `snp_supply` with the line's data and leaves the line Shared. A Modified line also asserts `snp_wb`. A Shared line only reports `snp_hold`.
- R8: A snooped read-for-ownership (opcode 2) that hits a Modified line supplies its data and invalidates it. On a Shared or Exclusive line it invalidates the line without supplying.
- R9: A snooped upgrade (opcode 3) on a Shared line invalidates it and never supplies. An Invalid line, or a line whose tag differs, ignores every snoop.
- R10: A miss whose victim is Modified first issues opcode 4 (writeback) with the victim's address and data, then the fill request. The request holds its address stable until granted.
- R11: While its own request is outstanding, or while a snoop is presented, `core_req_ready` is low. Snoops are answered during the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Controller accepts a request this cycle |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | ADDR_W | Word address (low IDX_W bits pick the line) |
| core_req_wdata | input | DATA_W | Write data |
| core_resp_valid | output | 1 | One-cycle response pulse |
| core_resp_hit | output | 1 | Request hit without bus traffic |
| core_resp_rdata | output | DATA_W | Read data, or the written word for writes |
| bus_req_valid | output | 1 | Own bus request pending |
| bus_req_op | output | 3 | 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| bus_req_addr | output | ADDR_W | Address of the request |
| bus_req_wdata | output | DATA_W | Victim data for writeback |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Granted transaction complete |
| bus_shared | input | 1 | Another cache holds the line (at completion) |
| bus_fill_data | input | DATA_W | Fill data at completion |
| snp_valid | input | 1 | Foreign transaction being broadcast |
| snp_op | input | 3 | Opcode of the foreign transaction |
| snp_addr | input | ADDR_W | Address of the foreign transaction |
| snp_hold | output | 1 | This cache holds a valid copy |
| snp_supply | output | 1 | This cache supplies the data |
| snp_wb | output | 1 | Supplied dirty data must also update memory |
| snp_data | output | DATA_W | Data supplied cache-to-cache |

## Verification
The assertions rely on the bus serialising transactions. Once this cache has been granted, no foreign snoop and no second grant arrives before `bus_done`, and `bus_done` only follows a grant. The bench keeps to this. It drives snoops only while the controller is idle or still waiting for its grant. It raises `bus_done` only in the cycle after it has granted a request that it saw pending. Snoop responses are combinational, so the bench reads them mid-cycle while `snp_valid` is held.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_RD   = 3'd1,
        OP_RDX  = 3'd2,
        OP_UPGR = 3'd3,
        OP_WB   = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {
        FSM_IDLE,
        FSM_REQ,
        FSM_WAIT
    } fsm_e;

    localparam int OP_W = 3;

    // State a line takes after observing a foreign transaction.
    function automatic mesi_e snoop_next(mesi_e cur, bus_op_e op);
        mesi_e nxt;
        nxt = cur;
        case (op)
            OP_RD:   if (cur == ST_E || cur == ST_M) nxt = ST_S;
            OP_RDX,
            OP_UPGR: nxt = ST_I;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic owns_line(mesi_e s);
        return (s == ST_E) || (s == ST_M);
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  mesi_e             fill_state,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  mesi_e             snp_state,
    output mesi_e             st_q   [LINES],
    output logic [TAG_W-1:0]  tag_q  [LINES],
    output logic [DATA_W-1:0] data_q [LINES]
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]   <= ST_I;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (fill_we && fill_idx == MY_IDX) begin
                st_q[i]   <= fill_state;
                tag_q[i]  <= fill_tag;
                data_q[i] <= fill_data;
            end else if (snp_we && snp_idx == MY_IDX) begin
                st_q[i]   <= snp_state;
            end
        end
    end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  bus_op_e           snp_op,
    input  logic [TAG_W-1:0]  snp_tag,
    input  mesi_e             line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              hold,
    output logic              supply,
    output logic              dirty_wb,
    output logic [DATA_W-1:0] supply_data,
    output logic              upd_we,
    output mesi_e             upd_state
);

    logic present;

    always_comb begin
        present     = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
        hold        = present;
        supply      = present && ((snp_op == OP_RD && owns_line(line_st)) ||
                                  (snp_op == OP_RDX && line_st == ST_M));
        dirty_wb    = present && snp_op == OP_RD && line_st == ST_M;
        supply_data = line_data;
        upd_we      = present && (snp_op == OP_RD || snp_op == OP_RDX || snp_op == OP_UPGR);
        upd_state   = snoop_next(line_st, snp_op);
    end

endmodule

// File: rtl/mesi_core_fsm.sv
module mesi_core_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req_valid,
    input  logic              core_req_write,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              core_req_ready,
    output logic              core_resp_valid,
    output logic              core_resp_hit,
    output logic [DATA_W-1:0] core_resp_rdata,
    input  logic              snp_busy,
    output logic [IDX_W-1:0]  look_idx,
    input  mesi_e             look_st,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [DATA_W-1:0] look_data,
    output logic              bus_req_valid,
    output bus_op_e           bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_fill_data,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [DATA_W-1:0] fill_data,
    output mesi_e             fill_state
);

    fsm_e              fsm_q, fsm_d;
    logic [ADDR_W-1:0] req_addr_q, req_addr_d;
    logic [DATA_W-1:0] req_wdata_q, req_wdata_d;
    bus_op_e           pend_op_q, pend_op_d;
    bus_op_e           fill_op_q, fill_op_d;
    bus_op_e           act_op_q, act_op_d;
    logic [ADDR_W-1:0] vic_addr_q, vic_addr_d;
    logic [DATA_W-1:0] vic_data_q, vic_data_d;
    logic              resp_valid_d, resp_hit_d;
    logic [DATA_W-1:0] resp_data_d;

    logic [TAG_W-1:0]  core_tag;
    logic [TAG_W-1:0]  req_tag;
    logic              accept;
    logic              look_hit;
    bus_op_e           eff_op;
    bus_op_e           miss_op;

    assign core_tag       = core_req_addr[ADDR_W-1:IDX_W];
    assign req_tag        = req_addr_q[ADDR_W-1:IDX_W];
    assign look_idx       = (fsm_q == FSM_IDLE) ? core_req_addr[IDX_W-1:0]
                                                : req_addr_q[IDX_W-1:0];
    assign core_req_ready = (fsm_q == FSM_IDLE) && !snp_busy;
    assign accept         = core_req_valid && core_req_ready;
    assign look_hit       = (look_st != ST_I) && (look_tag == core_tag);
    assign miss_op        = core_req_write ? OP_RDX : OP_RD;

    // An upgrade whose Shared copy was taken away must fetch the line again.
    assign eff_op = (pend_op_q == OP_UPGR && look_st != ST_S) ? OP_RDX : pend_op_q;

    assign bus_req_valid = (fsm_q == FSM_REQ);
    assign bus_req_op    = (fsm_q == FSM_REQ) ? eff_op : OP_NONE;
    assign bus_req_addr  = (pend_op_q == OP_WB) ? vic_addr_q : req_addr_q;
    assign bus_req_wdata = vic_data_q;

    always_comb begin
        fsm_d        = fsm_q;
        req_addr_d   = req_addr_q;
        req_wdata_d  = req_wdata_q;
        pend_op_d    = pend_op_q;
        fill_op_d    = fill_op_q;
        act_op_d     = act_op_q;
        vic_addr_d   = vic_addr_q;
        vic_data_d   = vic_data_q;
        resp_valid_d = 1'b0;
        resp_hit_d   = core_resp_hit;
        resp_data_d  = core_resp_rdata;
        fill_we      = 1'b0;
        fill_idx     = look_idx;
        fill_tag     = req_tag;
        fill_data    = req_wdata_q;
        fill_state   = ST_I;

        case (fsm_q)
            FSM_IDLE: begin
                if (accept) begin
                    req_addr_d  = core_req_addr;
                    req_wdata_d = core_req_wdata;
                    if (look_hit && !core_req_write) begin
                        resp_valid_d = 1'b1;
                        resp_hit_d   = 1'b1;
                        resp_data_d  = look_data;
                    end else if (look_hit && look_st != ST_S) begin
                        resp_valid_d = 1'b1;
                        resp_hit_d   = 1'b1;
                        resp_data_d  = core_req_wdata;
                        fill_we      = 1'b1;
                        fill_tag     = core_tag;
                        fill_data    = core_req_wdata;
                        fill_state   = ST_M;
                    end else if (look_hit) begin
                        pend_op_d = OP_UPGR;
                        fsm_d     = FSM_REQ;
                    end else begin
                        if (look_st == ST_M) begin
                            pend_op_d  = OP_WB;
                            fill_op_d  = miss_op;
                            vic_addr_d = {look_tag, look_idx};
                            vic_data_d = look_data;
                        end else begin
                            pend_op_d  = miss_op;
                        end
                        fsm_d = FSM_REQ;
                    end
                end
            end
            FSM_REQ: begin
                pend_op_d = eff_op;
                if (bus_gnt) begin
                    act_op_d = eff_op;
                    fsm_d    = FSM_WAIT;
                end
            end
            FSM_WAIT: begin
                if (bus_done) begin
                    fill_we = 1'b1;
                    case (act_op_q)
                        OP_WB: begin
                            fill_tag   = vic_addr_q[ADDR_W-1:IDX_W];
                            fill_data  = vic_data_q;
                            fill_state = ST_I;
                            pend_op_d  = fill_op_q;
                            fsm_d      = FSM_REQ;
                        end
                        OP_RD: begin
                            fill_data    = bus_fill_data;
                            fill_state   = bus_shared ? ST_S : ST_E;
                            resp_valid_d = 1'b1;
                            resp_hit_d   = 1'b0;
                            resp_data_d  = bus_fill_data;
                            fsm_d        = FSM_IDLE;
                        end
                        default: begin
                            fill_state   = ST_M;
                            resp_valid_d = 1'b1;
                            resp_hit_d   = 1'b0;
                            resp_data_d  = req_wdata_q;
                            fsm_d        = FSM_IDLE;
                        end
                    endcase
                end
            end
            default: fsm_d = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q           <= FSM_IDLE;
            req_addr_q      <= '0;
            req_wdata_q     <= '0;
            pend_op_q       <= OP_NONE;
            fill_op_q       <= OP_NONE;
            act_op_q        <= OP_NONE;
            vic_addr_q      <= '0;
            vic_data_q      <= '0;
            core_resp_valid <= 1'b0;
            core_resp_hit   <= 1'b0;
            core_resp_rdata <= '0;
        end else begin
            fsm_q           <= fsm_d;
            req_addr_q      <= req_addr_d;
            req_wdata_q     <= req_wdata_d;
            pend_op_q       <= pend_op_d;
            fill_op_q       <= fill_op_d;
            act_op_q        <= act_op_d;
            vic_addr_q      <= vic_addr_d;
            vic_data_q      <= vic_data_d;
            core_resp_valid <= resp_valid_d;
            core_resp_hit   <= resp_hit_d;
            core_resp_rdata <= resp_data_d;
        end
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req_valid,
    output logic              core_req_ready,
    input  logic              core_req_write,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              core_resp_valid,
    output logic              core_resp_hit,
    output logic [DATA_W-1:0] core_resp_rdata,
    output logic              bus_req_valid,
    output logic [2:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic [2:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hold,
    output logic              snp_supply,
    output logic              snp_wb,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    mesi_e             st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [IDX_W-1:0]  look_idx;
    logic              fill_we;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic [DATA_W-1:0] fill_data;
    mesi_e             fill_state;
    bus_op_e           own_op;

    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic              snp_we;
    mesi_e             snp_state;

    assign snp_idx    = snp_addr[IDX_W-1:0];
    assign snp_tag    = snp_addr[ADDR_W-1:IDX_W];
    assign bus_req_op = own_op;

    mesi_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_data (fill_data),
        .fill_state(fill_state),
        .snp_we    (snp_we),
        .snp_idx   (snp_idx),
        .snp_state (snp_state),
        .st_q      (st_q),
        .tag_q     (tag_q),
        .data_q    (data_q)
    );

    mesi_snoop_unit #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) snoop_i (
        .snp_valid  (snp_valid),
        .snp_op     (bus_op_e'(snp_op)),
        .snp_tag    (snp_tag),
        .line_st    (st_q[snp_idx]),
        .line_tag   (tag_q[snp_idx]),
        .line_data  (data_q[snp_idx]),
        .hold       (snp_hold),
        .supply     (snp_supply),
        .dirty_wb   (snp_wb),
        .supply_data(snp_data),
        .upd_we     (snp_we),
        .upd_state  (snp_state)
    );

    mesi_core_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) fsm_i (
        .clk            (clk),
        .rst            (rst),
        .core_req_valid (core_req_valid),
        .core_req_write (core_req_write),
        .core_req_addr  (core_req_addr),
        .core_req_wdata (core_req_wdata),
        .core_req_ready (core_req_ready),
        .core_resp_valid(core_resp_valid),
        .core_resp_hit  (core_resp_hit),
        .core_resp_rdata(core_resp_rdata),
        .snp_busy       (snp_valid),
        .look_idx       (look_idx),
        .look_st        (st_q[look_idx]),
        .look_tag       (tag_q[look_idx]),
        .look_data      (data_q[look_idx]),
        .bus_req_valid  (bus_req_valid),
        .bus_req_op     (own_op),
        .bus_req_addr   (bus_req_addr),
        .bus_req_wdata  (bus_req_wdata),
        .bus_gnt        (bus_gnt),
        .bus_done       (bus_done),
        .bus_shared     (bus_shared),
        .bus_fill_data  (bus_fill_data),
        .fill_we        (fill_we),
        .fill_idx       (fill_idx),
        .fill_tag       (fill_tag),
        .fill_data      (fill_data),
        .fill_state     (fill_state)
    );

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              core_req_ready,
    input logic              core_resp_valid,
    input logic              bus_req_valid,
    input logic [2:0]        bus_req_op,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [2:0]        snp_op,
    input logic              snp_hold,
    input logic              snp_supply,
    input logic              snp_wb
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_req_valid && !core_resp_valid && core_req_ready));

    // R11
    busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !core_req_ready);

    // R11
    snoop_stall_chk: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !core_req_ready);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_gnt) |=> (bus_req_valid && $stable(bus_req_addr)));

    // R2
    req_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> (bus_req_op >= 3'd1 && bus_req_op <= 3'd4));

    // R7
    wb_flag_chk: assert property (@(posedge clk) disable iff (rst)
        snp_wb |-> (snp_supply && snp_op == 3'd1));

    // R9
    upgr_nosupply_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_op == 3'd3) |-> !snp_supply);

    // R8
    supply_hold_chk: assert property (@(posedge clk) disable iff (rst)
        snp_supply |-> snp_hold);

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .core_req_ready (core_req_ready),
    .core_resp_valid(core_resp_valid),
    .bus_req_valid  (bus_req_valid),
    .bus_req_op     (bus_req_op),
    .bus_req_addr   (bus_req_addr),
    .bus_gnt        (bus_gnt),
    .snp_valid      (snp_valid),
    .snp_op         (snp_op),
    .snp_hold       (snp_hold),
    .snp_supply     (snp_supply),
    .snp_wb         (snp_wb)
);

// File: tb/mesi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_req_valid = 1'b0;
    logic        core_req_ready;
    logic        core_req_write = 1'b0;
    logic [7:0]  core_req_addr = '0;
    logic [15:0] core_req_wdata = '0;
    logic        core_resp_valid, core_resp_hit;
    logic [15:0] core_resp_rdata;
    logic        bus_req_valid;
    logic [2:0]  bus_req_op;
    logic [7:0]  bus_req_addr;
    logic [15:0] bus_req_wdata;
    logic        bus_gnt = 1'b0, bus_done = 1'b0, bus_shared = 1'b0;
    logic [15:0] bus_fill_data = '0;
    logic        snp_valid = 1'b0;
    logic [2:0]  snp_op = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_hold, snp_supply, snp_wb;
    logic [15:0] snp_data;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    mesi_snoop_ctrl dut_i (
        .clk(clk), .rst(rst),
        .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
        .core_req_write(core_req_write), .core_req_addr(core_req_addr),
        .core_req_wdata(core_req_wdata), .core_resp_valid(core_resp_valid),
        .core_resp_hit(core_resp_hit), .core_resp_rdata(core_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_shared(bus_shared),
        .bus_fill_data(bus_fill_data), .snp_valid(snp_valid), .snp_op(snp_op),
        .snp_addr(snp_addr), .snp_hold(snp_hold), .snp_supply(snp_supply),
        .snp_wb(snp_wb), .snp_data(snp_data)
    );

    // kind: 0 core read, 1 core write, 2 snoop. esnp = {hold, supply, wb}
    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  kind;
        logic [2:0]  sop;
        logic [7:0]  addr;
        logic [15:0] data;
        logic        shr;
        logic        ehit;
        logic [2:0]  eop;
        logic [15:0] erd;
        logic [2:0]  esnp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{4'd2, 2'd0, 3'd0, 8'h10, 16'hAAAA, 1'b0, 1'b0, 3'd1, 16'hAAAA, 3'b000}, // R2 miss -> E
        '{4'd3, 2'd0, 3'd0, 8'h10, 16'h0000, 1'b0, 1'b1, 3'd0, 16'hAAAA, 3'b000}, // R3 read hit
        '{4'd4, 2'd1, 3'd0, 8'h10, 16'h1111, 1'b0, 1'b1, 3'd0, 16'h1111, 3'b000}, // R4 silent E->M
        '{4'd7, 2'd2, 3'd1, 8'h10, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h1111, 3'b111}, // R7 M supplies + wb
        '{4'd7, 2'd2, 3'd1, 8'h10, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b100}, // R7 now S
        '{4'd5, 2'd1, 3'd0, 8'h10, 16'h2222, 1'b0, 1'b0, 3'd3, 16'h2222, 3'b000}, // R5 upgrade
        '{4'd8, 2'd2, 3'd2, 8'h10, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h2222, 3'b110}, // R8 M supplies on RdX
        '{4'd9, 2'd2, 3'd1, 8'h10, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b000}, // R9 invalid ignores
        '{4'd2, 2'd0, 3'd0, 8'h21, 16'h3333, 1'b1, 1'b0, 3'd1, 16'h3333, 3'b000}, // R2 miss -> S
        '{4'd2, 2'd2, 3'd1, 8'h21, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b100}, // R2 confirms S
        '{4'd9, 2'd2, 3'd3, 8'h21, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b100}, // R9 upgrade hits S
        '{4'd9, 2'd2, 3'd1, 8'h21, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b000}, // R9 now invalid
        '{4'd6, 2'd1, 3'd0, 8'h32, 16'h4444, 1'b0, 1'b0, 3'd2, 16'h4444, 3'b000}, // R6 write miss
        '{4'd9, 2'd2, 3'd1, 8'h36, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b000}, // R9 tag mismatch
        '{4'd6, 2'd2, 3'd1, 8'h32, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h4444, 3'b111}, // R6 line is M
        '{4'd8, 2'd0, 3'd0, 8'h13, 16'h5555, 1'b0, 1'b0, 3'd1, 16'h5555, 3'b000}, // R8 setup E
        '{4'd8, 2'd2, 3'd2, 8'h13, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b100}, // R8 E invalidated
        '{4'd8, 2'd2, 3'd1, 8'h13, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 3'b000}  // R8 confirms I
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic core_op(input logic wr, input logic [7:0] addr, input logic [15:0] wd,
                           input logic shr, input logic [15:0] fill,
                           output logic hit, output logic [15:0] rd, output int nops,
                           output logic [2:0] op0, output logic [2:0] op1,
                           output logic [7:0] a0, output logic [15:0] wbd0);
        logic got;
        got = 1'b0; nops = 0; hit = 1'b0; rd = '0;
        op0 = '0; op1 = '0; a0 = '0; wbd0 = '0;
        @(negedge clk);
        core_req_valid = 1'b1; core_req_write = wr;
        core_req_addr = addr; core_req_wdata = wd;
        check("R11 ready before request", {31'd0, core_req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        for (int k = 0; k < 20 && !got; k++) begin
            if (core_resp_valid) begin
                got = 1'b1; hit = core_resp_hit; rd = core_resp_rdata;
            end else if (bus_req_valid) begin
                if (nops == 0) begin
                    op0 = bus_req_op; a0 = bus_req_addr; wbd0 = bus_req_wdata;
                end else begin
                    op1 = bus_req_op;
                end
                nops++;
                bus_gnt = 1'b1;
                @(posedge clk);
                @(negedge clk);
                bus_gnt = 1'b0; bus_done = 1'b1;
                bus_fill_data = fill; bus_shared = shr;
                @(posedge clk);
                @(negedge clk);
                bus_done = 1'b0;
            end else begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        check("core response seen", {31'd0, got}, 32'd1);
    endtask

    task automatic snoop(input logic [2:0] op, input logic [7:0] addr,
                         output logic [2:0] flags, output logic [15:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = addr;
        #1;
        flags = {snp_hold, snp_supply, snp_wb};
        d = snp_data;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        logic        hit;
        logic [15:0] rd, wbd0, sd;
        logic [2:0]  op0, op1, fl;
        logic [7:0]  a0;
        int          nops;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready after reset", {31'd0, core_req_ready}, 32'd1);
        check("R1 no bus request after reset", {31'd0, bus_req_valid}, 32'd0);
        snoop(3'd1, 8'h10, fl, sd);
        check("R1 line 0 invalid", {29'd0, fl}, 32'd0);
        snoop(3'd1, 8'hFF, fl, sd);
        check("R1 line 3 invalid", {29'd0, fl}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].kind == 2'd2) begin
                snoop(VEC[i].sop, VEC[i].addr, fl, sd);
                check($sformatf("R%0d vec%0d snoop flags", VEC[i].req, i), {29'd0, fl}, {29'd0, VEC[i].esnp});
                if (VEC[i].esnp[1])
                    check($sformatf("R%0d vec%0d snoop data", VEC[i].req, i), {16'd0, sd}, {16'd0, VEC[i].erd});
            end else begin
                core_op(VEC[i].kind[0], VEC[i].addr, VEC[i].data, VEC[i].shr, VEC[i].data,
                        hit, rd, nops, op0, op1, a0, wbd0);
                check($sformatf("R%0d vec%0d hit", VEC[i].req, i), {31'd0, hit}, {31'd0, VEC[i].ehit});
                check($sformatf("R%0d vec%0d data", VEC[i].req, i), {16'd0, rd}, {16'd0, VEC[i].erd});
                check($sformatf("R%0d vec%0d bus ops", VEC[i].req, i), nops, (VEC[i].eop == 3'd0) ? 0 : 1);
                if (VEC[i].eop != 3'd0)
                    check($sformatf("R%0d vec%0d opcode", VEC[i].req, i), {29'd0, op0}, {29'd0, VEC[i].eop});
            end
        end

        // R10 eviction of a Modified line
        core_op(1'b1, 8'h40, 16'h6666, 1'b0, 16'h0, hit, rd, nops, op0, op1, a0, wbd0);
        check("R6 write miss opcode", {29'd0, op0}, 32'd2);
        core_op(1'b0, 8'h80, 16'h0, 1'b0, 16'h7777, hit, rd, nops, op0, op1, a0, wbd0);
        check("R10 two bus transactions", nops, 2);
        check("R10 first is writeback", {29'd0, op0}, 32'd4);
        check("R10 writeback address", {24'd0, a0}, 32'h40);
        check("R10 writeback data", {16'd0, wbd0}, 32'h6666);
        check("R10 then read", {29'd0, op1}, 32'd1);
        check("R10 fill data", {16'd0, rd}, 32'h7777);
        snoop(3'd1, 8'h40, fl, sd);
        check("R10 victim gone", {29'd0, fl}, 32'd0);
        snoop(3'd1, 8'h80, fl, sd);
        check("R10 new line exclusive", {29'd0, fl}, 32'b110);

        // R5 / R11 upgrade overtaken by a foreign read-for-ownership
        core_op(1'b0, 8'h51, 16'h0, 1'b1, 16'h3131, hit, rd, nops, op0, op1, a0, wbd0);
        @(negedge clk);
        core_req_valid = 1'b1; core_req_write = 1'b1;
        core_req_addr = 8'h51; core_req_wdata = 16'hABCD;
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        check("R5 upgrade requested", {28'd0, bus_req_valid, bus_req_op}, {28'd0, 1'b1, 3'd3});
        check("R11 stalled while pending", {31'd0, core_req_ready}, 32'd0);
        snp_valid = 1'b1; snp_op = 3'd2; snp_addr = 8'h51;
        #1;
        check("R11 snoop answered during stall", {31'd0, snp_hold}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        check("R5 turned into read-for-ownership", {28'd0, bus_req_valid, bus_req_op}, {28'd0, 1'b1, 3'd2});
        bus_gnt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_gnt = 1'b0; bus_done = 1'b1; bus_fill_data = 16'h9999; bus_shared = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bus_done = 1'b0;
        check("R5 response", {15'd0, core_resp_valid, core_resp_hit, core_resp_rdata},
              {15'd0, 1'b1, 1'b0, 16'hABCD});
        snoop(3'd1, 8'h51, fl, sd);
        check("R5 line ended modified", {29'd0, fl}, 32'b111);
        check("R5 line data", {16'd0, sd}, 32'hABCD);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule